// File: doc/BRIEF.md
# Serial Flash Status Register and Write Guard

This block holds the eight-bit status byte of a serial NOR flash and decides whether each write-class command may go ahead. A command decoder elsewhere presents one command per cycle as a kind code, with the target address and, for a status write, the data byte. The guard answers with a one-cycle grant or deny pulse and updates its status bits. The erase and program engine reports its busy state and its completion events back to the guard. The guard then clears the write-enable latch and the auto-increment flag when those events arrive.

Protection uses a three-bit code. The code selects a power-of-two fraction of the 64 KB blocks, counted either from the top of the array or from the bottom, as chosen by a strap pin. A lock bit freezes the status byte while the write-protect pin is low. A status write is accepted only when the command just before it armed it. The protected-address flag is purely combinational, so the decoder can use it in the same cycle it presents the address.

Top module: `flash_status_guard`

## Requirements
- R1: Status bit positions are: 0 busy, 1 write-enable latch, 2..4 protect code (bit 2 is the LSB), 5 reserved and always 0, 6 auto-increment mode, 7 lock. After reset the status byte is 0x1C (protect code 111, all other stored bits 0).
- R2: Kind 0 (enable-write) sets the write-enable latch. Kind 1 (disable-write) clears the latch and the auto-increment flag. Both are always granted.
- R3: Kind 3 (status write) is granted only when the command just before it was kind 0 or kind 2 (arm). Any other command clears the arming. Only data bits 2..4 and 7 are stored. A granted status write clears the write-enable latch.
- R4: A status write is denied when the protect pin is low and the lock bit is 1. With the pin high, the write is granted whatever the lock value, and it may clear the lock.
- R5: Top strap (bottom_sel=0): codes 1..5 protect blocks (address bits 20..16) from 31, 30, 28, 24 and 16 upward. Codes 6 and 7 protect every block, and code 0 protects none.
- R6: Bottom strap (bottom_sel=1): codes 1..5 protect blocks below 1, 2, 4, 8 and 16. Codes 6 and 7 protect all blocks, and code 0 protects none.
- R7: Kinds 4 (program), 5 (sector erase), 6 (block erase) and 8 (auto-increment start) are denied when the write-enable latch is 0 or addr_protected is 1, and granted otherwise. A granted kind 8 sets the auto-increment flag.
- R8: Kind 7 (chip erase) is granted only when the latch is 1 and the protect code is 000.
- R9: done_evt clears the write-enable latch. aai_exit clears the latch and the auto-increment flag. These clears win over a command in the same cycle.
- R10: grant and deny are registered one-cycle pulses in the cycle after the command. A denied command leaves every stored status bit unchanged. Kind 9 (any other command) gives neither pulse.
- R11: Status bit 0 follows engine_busy in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_kind | input | 4 | Command kind code (see requirements) |
| cmd_data | input | 8 | Data byte for a status write |
| cmd_addr | input | ADDR_W | Target address of a program or erase |
| wp_pin | input | 1 | Write-protect pin level (low = protect active) |
| bottom_sel | input | 1 | Protection anchored at the bottom when 1 |
| engine_busy | input | 1 | Busy state of the program/erase engine |
| done_evt | input | 1 | Pulse: program or erase finished |
| aai_exit | input | 1 | Pulse: auto-increment programming ended |
| status | output | 8 | Status byte |
| grant | output | 1 | Pulse: command accepted |
| deny | output | 1 | Pulse: command refused |
| addr_protected | output | 1 | Target block lies in the protected range |

## Verification
Several rules are checked on every cycle: the reserved bit stays zero, grant and deny never coincide, and a denied command leaves the stored bits frozen. The checks also cover the refusal of a status write under an active lock, the lock falling only while the pin is high, the latch clearing after a granted status write, chip-erase refusal under a non-zero code, and busy mirroring. The protect decode for every code, strap and block can only be shown by the bench's sweep. The same holds for arming being lost to an intervening command and for event-clear priority. Long mixed command streams check the grant and deny decisions against an independent model.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  typedef enum logic [3:0] {
    K_WREN  = 4'd0,
    K_WRDI  = 4'd1,
    K_ARM   = 4'd2,
    K_WRSR  = 4'd3,
    K_PROG  = 4'd4,
    K_SECT  = 4'd5,
    K_BLK   = 4'd6,
    K_CHIP  = 4'd7,
    K_AAI   = 4'd8,
    K_OTHER = 4'd9
  } cmd_kind_e;

  localparam int SR_W     = 8;
  localparam int BP_W     = 3;
  localparam int SR_LOCK  = 7;
  localparam int SR_BP_LO = 2;

  typedef struct packed {
    logic            lock;
    logic            aai;
    logic [BP_W-1:0] bp;
    logic            wel;
  } sr_state_t;

endpackage

// File: rtl/fsg_rst_sync.sv
module fsg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/fsg_prot_decode.sv
module fsg_prot_decode #(
  parameter int BLK_W = 5,
  parameter int BP_W  = 3
) (
  input  logic [BP_W-1:0]  bp,
  input  logic             bottom_sel,
  input  logic [BLK_W-1:0] blk,
  output logic             prot
);
  // Codes 1..NFRAC select a fraction; higher codes cover everything.
  localparam int NFRAC = 5;

  logic [NFRAC:1][BLK_W-1:0] hi_mask;

  // Mask of block bits that must match for each fractional code.
  for (genvar c = 1; c <= NFRAC; c++) begin : g_code
    for (genvar i = 0; i < BLK_W; i++) begin : g_bit
      assign hi_mask[c][i] = (i >= (BLK_W - NFRAC - 1 + c)) ? 1'b1 : 1'b0;
    end
  end

  logic [BLK_W-1:0] sel_mask;
  logic             in_top;
  logic             in_bot;

  always_comb begin
    sel_mask = '0;
    for (int c = 1; c <= NFRAC; c++) begin
      if (int'(bp) == c) sel_mask = hi_mask[c];
    end
    in_top = ((blk & sel_mask) == sel_mask);
    in_bot = ((blk & sel_mask) == '0);
    if (bp == '0)                prot = 1'b0;
    else if (int'(bp) > NFRAC)   prot = 1'b1;
    else                         prot = bottom_sel ? in_bot : in_top;
  end
endmodule

// File: rtl/fsg_arm_track.sv
module fsg_arm_track (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic arm_cmd,
  output logic armed
);
  logic armed_d;

  // Every command overwrites the arming; only an arming command sets it.
  always_comb begin
    armed_d = armed;
    if (cmd_valid) armed_d = arm_cmd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= armed_d;
  end
endmodule

// File: rtl/fsg_status_regs.sv
module fsg_status_regs
  import fsg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_wel,
  input  logic            clr_wel,
  input  logic            set_aai,
  input  logic            clr_aai,
  input  logic            ld_cfg,
  input  logic [BP_W-1:0] ld_bp,
  input  logic            ld_lock,
  output sr_state_t       st
);
  sr_state_t st_d;

  always_comb begin
    st_d = st;
    if (set_wel) st_d.wel = 1'b1;
    if (clr_wel) st_d.wel = 1'b0;
    if (set_aai) st_d.aai = 1'b1;
    if (clr_aai) st_d.aai = 1'b0;
    if (ld_cfg) begin
      st_d.bp   = ld_bp;
      st_d.lock = ld_lock;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st.lock <= 1'b0;
      st.aai  <= 1'b0;
      st.bp   <= '1;
      st.wel  <= 1'b0;
    end else begin
      st <= st_d;
    end
  end
endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard
  import fsg_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int BLK_LSB = 16,
  parameter int BLK_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_kind,
  input  logic [7:0]        cmd_data,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              wp_pin,
  input  logic              bottom_sel,
  input  logic              engine_busy,
  input  logic              done_evt,
  input  logic              aai_exit,
  output logic [7:0]        status,
  output logic              grant,
  output logic              deny,
  output logic              addr_protected
);
  localparam int BLK_HI = BLK_LSB + BLK_W;

  logic      rst_q_n;
  sr_state_t st;
  logic      armed;
  cmd_kind_e kind;
  logic [BLK_W-1:0] blk;

  logic unused_bits;
  assign unused_bits = ^{cmd_addr[BLK_LSB-1:0], cmd_addr[ADDR_W-1:BLK_HI],
                         cmd_data[6:5], cmd_data[1:0]};

  assign kind = cmd_kind_e'(cmd_kind);
  assign blk  = cmd_addr[BLK_LSB +: BLK_W];

  fsg_rst_sync #(.STAGES(2)) u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_q_n)
  );

  fsg_prot_decode #(.BLK_W(BLK_W), .BP_W(BP_W)) u_prot (
    .bp        (st.bp),
    .bottom_sel(bottom_sel),
    .blk       (blk),
    .prot      (addr_protected)
  );

  fsg_arm_track u_arm (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .cmd_valid(cmd_valid),
    .arm_cmd  ((kind == K_WREN) || (kind == K_ARM)),
    .armed    (armed)
  );

  // Permission decision
  logic ok;
  logic judged;
  logic locked_out;

  always_comb begin
    locked_out = !wp_pin && st.lock;
    ok         = 1'b0;
    judged     = 1'b1;
    unique case (kind)
      K_WREN, K_WRDI, K_ARM: ok = 1'b1;
      K_WRSR:                ok = armed && !locked_out;
      K_PROG, K_SECT, K_BLK, K_AAI:
                             ok = st.wel && !addr_protected;
      K_CHIP:                ok = st.wel && (st.bp == '0);
      default:               judged = 1'b0;
    endcase
  end

  logic acc;
  logic rej;
  assign acc = cmd_valid && judged && ok;
  assign rej = cmd_valid && judged && !ok;

  logic set_wel, clr_wel, set_aai, clr_aai, ld_cfg;

  always_comb begin
    set_wel = acc && (kind == K_WREN);
    clr_wel = (acc && ((kind == K_WRDI) || (kind == K_WRSR))) || done_evt || aai_exit;
    set_aai = acc && (kind == K_AAI);
    clr_aai = (acc && (kind == K_WRDI)) || aai_exit;
    ld_cfg  = acc && (kind == K_WRSR);
  end

  fsg_status_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .set_wel(set_wel),
    .clr_wel(clr_wel),
    .set_aai(set_aai),
    .clr_aai(clr_aai),
    .ld_cfg (ld_cfg),
    .ld_bp  (cmd_data[SR_BP_LO +: BP_W]),
    .ld_lock(cmd_data[SR_LOCK]),
    .st     (st)
  );

  // Response pulses
  logic grant_d, deny_d;

  always_comb begin
    grant_d = acc;
    deny_d  = rej;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      grant <= 1'b0;
      deny  <= 1'b0;
    end else begin
      grant <= grant_d;
      deny  <= deny_d;
    end
  end

  assign status = {st.lock, st.aai, 1'b0, st.bp, st.wel, engine_busy};
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker
  import fsg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [3:0] cmd_kind,
  input logic       wp_pin,
  input logic       engine_busy,
  input logic       done_evt,
  input logic       aai_exit,
  input logic [7:0] status,
  input logic       grant,
  input logic       deny
);
  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[5] == 1'b0);

  // R10
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && deny));

  // R10
  deny_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !done_evt && !aai_exit ##1 deny |-> status[7:1] == $past(status[7:1]));

  // R4
  lock_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_kind == K_WRSR) && !wp_pin && status[7] |=> deny);

  // R4
  lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[7]) |-> $past(wp_pin));

  // R3
  wrsr_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_kind == K_WRSR) |=> (!grant || !status[1]));

  // R8
  chip_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_kind == K_CHIP) && (status[4:2] != 3'b000) |=> deny);

  // R11
  busy_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] == engine_busy);
endmodule

bind flash_status_guard fsg_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_kind   (cmd_kind),
  .wp_pin     (wp_pin),
  .engine_busy(engine_busy),
  .done_evt   (done_evt),
  .aai_exit   (aai_exit),
  .status     (status),
  .grant      (grant),
  .deny       (deny)
);

// File: tb/flash_status_guard_tb.sv
module flash_status_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [3:0]  cmd_kind;
  logic [7:0]  cmd_data;
  logic [23:0] cmd_addr;
  logic        wp_pin, bottom_sel, engine_busy, done_evt, aai_exit;
  logic [7:0]  status;
  logic        grant, deny, addr_protected;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // model state
  logic m_wel, m_aai, m_lock, m_arm;
  logic [2:0] m_bp;

  always #4 clk = ~clk;

  flash_status_guard u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_data(cmd_data), .cmd_addr(cmd_addr), .wp_pin(wp_pin),
    .bottom_sel(bottom_sel), .engine_busy(engine_busy), .done_evt(done_evt),
    .aai_exit(aai_exit), .status(status), .grant(grant), .deny(deny),
    .addr_protected(addr_protected)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_prot(logic [2:0] bp, logic bot, logic [4:0] blk);
    int lb_top[5] = '{31, 30, 28, 24, 16};
    int cnt_bot[5] = '{1, 2, 4, 8, 16};
    if (bp == 0) return 1'b0;
    if (bp >= 6) return 1'b1;
    if (bot) return int'(blk) < cnt_bot[bp-1];
    return int'(blk) >= lb_top[bp-1];
  endfunction

  function automatic logic [7:0] exp_status();
    return {m_lock, m_aai, 1'b0, m_bp, m_wel, engine_busy};
  endfunction

  task automatic apply(string req, int kind, logic [7:0] data, logic [23:0] addr,
                       logic wp, logic bot);
    logic g, d, prot;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = 4'(kind); cmd_data = data; cmd_addr = addr;
    wp_pin = wp; bottom_sel = bot;
    #1;
    prot = exp_prot(m_bp, bot, addr[20:16]);
    check({req, " prot"}, {31'd0, addr_protected}, {31'd0, prot});
    g = 1'b0; d = 1'b0;
    case (kind)
      0, 1, 2: g = 1'b1;
      3: begin g = m_arm && !(!wp && m_lock); d = !g; end
      4, 5, 6, 8: begin g = m_wel && !prot; d = !g; end
      7: begin g = m_wel && (m_bp == 3'b000); d = !g; end
      default: ;
    endcase
    if (g) begin
      case (kind)
        0: m_wel = 1'b1;
        1: begin m_wel = 1'b0; m_aai = 1'b0; end
        3: begin m_bp = data[4:2]; m_lock = data[7]; m_wel = 1'b0; end
        8: m_aai = 1'b1;
        default: ;
      endcase
    end
    m_arm = (kind == 0) || (kind == 2);
    @(negedge clk);
    cmd_valid = 1'b0;
    check({req, " grant"}, {31'd0, grant}, {31'd0, g});
    check({req, " deny"}, {31'd0, deny}, {31'd0, d});
    check({req, " status"}, {24'd0, status}, {24'd0, exp_status()});
  endtask

  task automatic event_cyc(logic dn, logic ax);
    @(negedge clk);
    done_evt = dn; aai_exit = ax;
    if (dn || ax) m_wel = 1'b0;
    if (ax) m_aai = 1'b0;
    @(negedge clk);
    done_evt = 1'b0; aai_exit = 1'b0;
    check("R9 event status", {24'd0, status}, {24'd0, exp_status()});
    check("R10 no pulse idle", {30'd0, grant, deny}, 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_kind = 4'd9; cmd_data = 8'h00;
    cmd_addr = 24'h0; wp_pin = 1'b1; bottom_sel = 1'b0; engine_busy = 1'b0;
    done_evt = 1'b0; aai_exit = 1'b0;
    m_wel = 0; m_aai = 0; m_lock = 0; m_arm = 0; m_bp = 3'b111;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset value
    check("R1 reset status", {24'd0, status}, 32'h1C);
    check("R1 reset pulses", {30'd0, grant, deny}, 32'd0);
    // R11 busy mirror
    engine_busy = 1'b1; #1;
    check("R11 busy", {31'd0, status[0]}, 32'd1);
    engine_busy = 1'b0;

    // R7 program without latch
    apply("R7 prog no wel", 4, 8'h00, 24'h000000, 1'b1, 1'b0);
    // R3 unarmed status write
    apply("R3 unarmed", 3, 8'h00, 24'h0, 1'b1, 1'b0);
    apply("R3 arm", 2, 8'h00, 24'h0, 1'b1, 1'b0);
    apply("R3 write ffcode ignored bits", 3, 8'h63, 24'h0, 1'b1, 1'b0);
    // R3 cancel by intervening command
    apply("R2 wren", 0, 8'h00, 24'h0, 1'b1, 1'b0);
    apply("R3 other", 9, 8'h00, 24'h0, 1'b1, 1'b0);
    apply("R3 cancelled", 3, 8'h1C, 24'h0, 1'b1, 1'b0);
    // R4 set lock with pin low
    apply("R2 wren", 0, 8'h00, 24'h0, 1'b0, 1'b0);
    apply("R4 set lock", 3, 8'h94, 24'h0, 1'b0, 1'b0);
    apply("R4 arm", 2, 8'h00, 24'h0, 1'b0, 1'b0);
    apply("R4 locked", 3, 8'h00, 24'h0, 1'b0, 1'b0);
    apply("R4 arm", 2, 8'h00, 24'h0, 1'b1, 1'b0);
    apply("R4 pin high unlock", 3, 8'h00, 24'h0, 1'b1, 1'b0);

    // R5 R6 full decode sweep
    for (int code = 0; code < 8; code++) begin
      apply("R3 arm", 2, 8'h00, 24'h0, 1'b1, 1'b0);
      apply("R3 set code", 3, 8'(code << 2), 24'h0, 1'b1, 1'b0);
      for (int bot = 0; bot < 2; bot++) begin
        for (int b = 0; b < 32; b++) begin
          cmd_addr = {3'b000, 5'(b), 16'h5A5A}; bottom_sel = 1'(bot); #1;
          check(bot ? "R6 bottom decode" : "R5 top decode",
                {31'd0, addr_protected},
                {31'd0, exp_prot(3'(code), 1'(bot), 5'(b))});
        end
      end
    end

    // R8 chip erase
    apply("R3 arm", 2, 8'h00, 24'h0, 1'b1, 1'b0);
    apply("R3 code4", 3, 8'h10, 24'h0, 1'b1, 1'b0);
    apply("R2 wren", 0, 8'h00, 24'h0, 1'b1, 1'b0);
    apply("R8 chip denied", 7, 8'h00, 24'h0, 1'b1, 1'b0);
    apply("R2 wren", 0, 8'h00, 24'h0, 1'b1, 1'b0);
    apply("R3 code0", 3, 8'h00, 24'h0, 1'b1, 1'b0);
    apply("R2 wren", 0, 8'h00, 24'h0, 1'b1, 1'b0);
    apply("R8 chip granted", 7, 8'h00, 24'h0, 1'b1, 1'b0);
    event_cyc(1'b1, 1'b0);
    // R9 auto-increment flag
    apply("R2 wren", 0, 8'h00, 24'h0, 1'b1, 1'b0);
    apply("R7 aai start", 8, 8'h00, 24'h120000, 1'b1, 1'b0);
    event_cyc(1'b0, 1'b1);
    apply("R2 wren", 0, 8'h00, 24'h0, 1'b1, 1'b0);
    apply("R7 aai start", 8, 8'h00, 24'h120000, 1'b1, 1'b0);
    apply("R2 wrdi", 1, 8'h00, 24'h0, 1'b1, 1'b0);

    // Random mix
    for (int it = 0; it < 1500; it++) begin
      int k;
      int r;
      r = int'($urandom_range(0, 99));
      engine_busy = 1'($urandom_range(0, 1));
      if (r < 8) begin
        event_cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end else begin
        k = (r < 30) ? 0 : (r < 40) ? 2 : (r < 55) ? 3 : int'($urandom_range(0, 9));
        apply("R7 random", k, 8'($urandom), 24'($urandom),
              1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)));
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule